// File: doc/BRIEF.md
# Sequential Integer Lifting Wavelet Engine

This block computes a single-level, one-dimensional integer wavelet decomposition of one slowly sampled stream. Samples arrive one at a time and are grouped into even/odd pairs. The even sample is only stored. When the odd sample arrives, the engine runs five lifting steps in turn on one shared three-term arithmetic core and then produces one approximation word and one detail word.

Each step has the form `b + round((ka*a + kc*c)/16)`. The pass-through operand `b` is always the result of the step before it, and the odd sample serves as `b` for the first step. A per-phase table chooses the operands `a` and `c` and the two coefficient ROM addresses. It also marks the phases that use only one product. In those phases the second product is forced to zero. Values that carry from one pair to the next are held in four registers. These registers start at zero, so the first outputs after reset act as if the stream had been zero-padded. The final normalisation scaling is not applied.

Because the core runs five times per pair, the sample rate must be slow enough to leave five idle clocks after each odd sample.

Top module: `dwt_seq_lift`

## Requirements
- R1: While reset is held and just after it is released, `out_valid` is 0 and `approx_o` and `detail_o` are 0.
- R2: The first accepted sample after reset, and the first after each completed pair, is the even sample. It is only stored and produces no output. The next accepted sample is the odd sample and starts the five-step computation.
- R3: Each step computes `wrap10(b + ((ka*a + kc*c + 8) >>> 4))` in signed integers. Here `>>>` is an arithmetic shift, so the division rounds to the nearest integer, with exact halves rounding up. `wrap10` keeps the low 10 bits as two's complement. In single-product steps the `kc*c` term is 0.
- R4: The coefficient ROM holds eight signed 6-bit values. In address order they are -13, 5, 11, -3, 7, -9, 4, -6 (k0..k7). For a pair (e, o), with carries c1, c2, c3 and ce, the five steps are:
  - s1 = step(b=o, k0·e, k1·c1)
  - s2 = step(b=s1, k2·e, k3·c2)
  - s3 = step(b=s2, k4·c3, k5·ce)
  - s4 = step(b=s3, k6·e), single product
  - s5 = step(b=s4, k7·s2), single product
- R5: After each pair the carries are updated: c1=s1, c2=s2, c3=s3 and ce=e. All carries are 0 after reset.
- R6: `out_valid` is a single-cycle pulse. It rises after the fifth rising edge that follows the edge accepting the odd sample. In that same cycle `detail_o` = s4 and `approx_o` = s5.
- R7: `approx_o` and `detail_o` keep their values between pulses.
- R8: `in_valid` must stay low during the five compute cycles that follow the acceptance of an odd sample.
- R9: A reset applied after an even sample but before its odd sample discards that even sample. It also restores even pairing and clears the carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sample | input | 10 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking new coefficients |
| approx_o | output | 10 | Signed approximation coefficient |
| detail_o | output | 10 | Signed detail coefficient |

## Verification
The assertions assume that the source never presents a sample while the engine is computing. Under that assumption the step marker is at most one-hot, each pulse follows the last step, and the outputs change only during computation. The bench keeps to this by sending each pair on two consecutive cycles. It then holds `in_valid` low for at least six cycles before the next pair. Inputs include the full-scale values 511 and -512, so the wrap rule is exercised without breaking the spacing assumption.

// File: rtl/dwt_seq_pkg.sv
package dwt_seq_pkg;

  typedef enum logic [2:0] {
    SRC_EVEN = 3'd0,
    SRC_C1   = 3'd1,
    SRC_C2   = 3'd2,
    SRC_C3   = 3'd3,
    SRC_CE   = 3'd4
  } src_e;

  typedef struct packed {
    src_e       sel_a;
    src_e       sel_c;
    logic [2:0] adr_a;
    logic [2:0] adr_c;
    logic       single;
  } phase_t;

  // R4: quantised lifting coefficients, scaled by 16
  function automatic int coef_val(input int idx);
    case (idx)
      0: coef_val = -13;
      1: coef_val = 5;
      2: coef_val = 11;
      3: coef_val = -3;
      4: coef_val = 7;
      5: coef_val = -9;
      6: coef_val = 4;
      default: coef_val = -6;
    endcase
  endfunction

  // R4: per-phase operand selection and coefficient addresses
  function automatic phase_t phase_entry(input int idx);
    phase_t p;
    case (idx)
      0: p = '{sel_a: SRC_EVEN, sel_c: SRC_C1, adr_a: 3'd0, adr_c: 3'd1, single: 1'b0};
      1: p = '{sel_a: SRC_EVEN, sel_c: SRC_C2, adr_a: 3'd2, adr_c: 3'd3, single: 1'b0};
      2: p = '{sel_a: SRC_C3,   sel_c: SRC_CE, adr_a: 3'd4, adr_c: 3'd5, single: 1'b0};
      3: p = '{sel_a: SRC_EVEN, sel_c: SRC_EVEN, adr_a: 3'd6, adr_c: 3'd6, single: 1'b1};
      default: p = '{sel_a: SRC_C2, sel_c: SRC_C2, adr_a: 3'd7, adr_c: 3'd7, single: 1'b1};
    endcase
    return p;
  endfunction

  // R3: three-term lifting step with round-to-nearest
  function automatic int lift_step(input int b, input int ka, input int a,
                                   input int kc, input int c,
                                   input bit single, input int frac);
    int acc;
    acc = ka * a + (single ? 0 : kc * c) + (1 <<< (frac - 1));
    return b + (acc >>> frac);
  endfunction

endpackage

// File: rtl/dwt_pair_ctrl.sv
module dwt_pair_ctrl #(
  parameter int NSTEP = 5,
  localparam int SW = $clog2(NSTEP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             take_even,
  output logic             take_odd,
  output logic             busy,
  output logic [NSTEP-1:0] step_oh,
  output logic [SW-1:0]    step_idx
);
  logic odd_next;

  assign busy      = |step_oh;
  assign take_even = in_valid && !busy && !odd_next;
  assign take_odd  = in_valid && !busy &&  odd_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_next <= 1'b0;
      step_oh  <= '0;
    end else begin
      if (take_even)     odd_next <= 1'b1;
      else if (take_odd) odd_next <= 1'b0;
      step_oh <= {step_oh[NSTEP-2:0], take_odd};
    end
  end

  always_comb begin
    step_idx = '0;
    for (int i = 0; i < NSTEP; i++) begin
      if (step_oh[i]) step_idx = SW'(i);
    end
  end
endmodule

// File: rtl/dwt_coef_rom.sv
module dwt_coef_rom #(
  parameter int COEF_W = 6,
  parameter int DEPTH  = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0]            adr_a,
  input  logic [AW-1:0]            adr_c,
  output logic signed [COEF_W-1:0] k_a,
  output logic signed [COEF_W-1:0] k_c
);
  logic signed [COEF_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = COEF_W'(dwt_seq_pkg::coef_val(g));
  end

  assign k_a = rom[adr_a];
  assign k_c = rom[adr_c];
endmodule

// File: rtl/dwt_lift_core.sv
module dwt_lift_core #(
  parameter int DATA_W = 10,
  parameter int COEF_W = 6,
  parameter int FRAC   = 4
) (
  input  logic signed [DATA_W-1:0] op_a,
  input  logic signed [DATA_W-1:0] op_b,
  input  logic signed [DATA_W-1:0] op_c,
  input  logic signed [COEF_W-1:0] k_a,
  input  logic signed [COEF_W-1:0] k_c,
  input  logic                     single,
  output logic signed [DATA_W-1:0] res
);
  int full;

  // R3: second product gated off in single-product phases
  always_comb begin
    full = dwt_seq_pkg::lift_step(int'(op_b), int'(k_a), int'(op_a),
                                  int'(k_c), int'(op_c), single, FRAC);
    res  = DATA_W'(full);
  end
endmodule

// File: rtl/dwt_seq_lift.sv
module dwt_seq_lift #(
  parameter int DATA_W = 10,
  parameter int COEF_W = 6,
  parameter int NSTEP  = 5,
  parameter int ROM_N  = 8,
  parameter int FRAC   = 4,
  localparam int SW = $clog2(NSTEP),
  localparam int AW = $clog2(ROM_N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] approx_o,
  output logic signed [DATA_W-1:0] detail_o
);
  import dwt_seq_pkg::*;

  logic take_even, take_odd, busy;
  logic [NSTEP-1:0] step_oh;
  logic [SW-1:0]    step_idx;

  logic signed [DATA_W-1:0] even_q, acc_q, c1_q, c2_q, c3_q, ce_q;
  logic signed [DATA_W-1:0] op_a, op_c, res;
  logic signed [COEF_W-1:0] k_a, k_c;
  phase_t ph;
  logic step_first, step_last, step_detail;

  dwt_pair_ctrl #(.NSTEP(NSTEP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .take_even(take_even), .take_odd(take_odd), .busy(busy),
    .step_oh(step_oh), .step_idx(step_idx)
  );

  assign ph          = phase_entry(int'(step_idx));
  assign step_first  = step_oh[0];
  assign step_detail = step_oh[NSTEP-2];
  assign step_last   = step_oh[NSTEP-1];

  function automatic logic signed [DATA_W-1:0] pick(input src_e s,
      input logic signed [DATA_W-1:0] ev, input logic signed [DATA_W-1:0] r1,
      input logic signed [DATA_W-1:0] r2, input logic signed [DATA_W-1:0] r3,
      input logic signed [DATA_W-1:0] re);
    case (s)
      SRC_EVEN: pick = ev;
      SRC_C1:   pick = r1;
      SRC_C2:   pick = r2;
      SRC_C3:   pick = r3;
      default:  pick = re;
    endcase
  endfunction

  assign op_a = pick(ph.sel_a, even_q, c1_q, c2_q, c3_q, ce_q);
  assign op_c = pick(ph.sel_c, even_q, c1_q, c2_q, c3_q, ce_q);

  dwt_coef_rom #(.COEF_W(COEF_W), .DEPTH(ROM_N)) u_rom (
    .adr_a(AW'(ph.adr_a)), .adr_c(AW'(ph.adr_c)), .k_a(k_a), .k_c(k_c)
  );

  dwt_lift_core #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_core (
    .op_a(op_a), .op_b(acc_q), .op_c(op_c), .k_a(k_a), .k_c(k_c),
    .single(ph.single), .res(res)
  );

  // R2, R5: sample capture, step accumulator and carries
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      even_q <= '0;
      acc_q  <= '0;
      c1_q   <= '0;
      c2_q   <= '0;
      c3_q   <= '0;
      ce_q   <= '0;
    end else begin
      if (take_even) even_q <= in_sample;
      if (take_odd)  acc_q  <= in_sample;
      else if (busy) acc_q  <= res;
      if (step_first)  c1_q <= res;
      if (step_oh[1])  c2_q <= res;
      if (step_oh[2]) begin
        c3_q <= res;
        ce_q <= even_q;
      end
    end
  end

  // R6, R7: result registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      approx_o  <= '0;
      detail_o  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= step_last;
      if (step_detail) detail_o <= res;
      if (step_last)   approx_o <= res;
    end
  end
endmodule

// File: rtl/dwt_seq_lift_chk.sv
module dwt_seq_lift_chk #(
  parameter int DATA_W = 10,
  parameter int NSTEP  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              busy,
  input logic [NSTEP-1:0]  step_oh,
  input logic              out_valid,
  input logic [DATA_W-1:0] approx_o,
  input logic [DATA_W-1:0] detail_o
);
  p_step_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_oh));

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_pulse_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_oh[NSTEP-1] |=> out_valid);

  p_pulse_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(step_oh[NSTEP-1]));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(approx_o) && $stable(detail_o)));

  p_input_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_valid);
endmodule

bind dwt_seq_lift dwt_seq_lift_chk #(.DATA_W(DATA_W), .NSTEP(NSTEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
  .step_oh(step_oh), .out_valid(out_valid),
  .approx_o(approx_o), .detail_o(detail_o)
);

// File: tb/tb_dwt_seq_lift.sv
module tb_dwt_seq_lift;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam int VEC [NVEC][2] = '{
    '{100, -37}, '{5, 3}, '{511, 511}, '{-512, -512},
    '{-200, 300}, '{0, 0}, '{77, -1}, '{-1, 256}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic signed [9:0] in_sample = '0;
  logic out_valid;
  logic signed [9:0] approx_o, detail_o;

  int checks = 0, failures = 0;
  int m1, m2, m3, me;
  int exp_a, exp_d;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwt_seq_lift dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .approx_o(approx_o), .detail_o(detail_o)
  );

  function automatic int wrap10(input int x);
    int t;
    t = x & 1023;
    return (t >= 512) ? t - 1024 : t;
  endfunction

  function automatic int rnd16(input int x);
    int q;
    q = (x + 8) / 16;
    if ((x + 8) < 0 && (q * 16) != (x + 8)) q = q - 1;
    return q;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_pair(input int e, input int o);
    int s1, s2, s3, s4, s5;
    s1 = wrap10(o  + rnd16(-13 * e + 5 * m1));
    s2 = wrap10(s1 + rnd16(11 * e - 3 * m2));
    s3 = wrap10(s2 + rnd16(7 * m3 - 9 * me));
    s4 = wrap10(s3 + rnd16(4 * e));
    s5 = wrap10(s4 + rnd16(-6 * s2));
    m1 = s1; m2 = s2; m3 = s3; me = e;
    exp_d = s4; exp_a = s5;
  endtask

  task automatic run_pair(input int e, input int o);
    @(negedge clk); in_valid = 1; in_sample = 10'(e);
    @(negedge clk); in_sample = 10'(o);
    @(negedge clk); in_valid = 0;
    model_pair(e, o);
    repeat (4) @(posedge clk);
    #1 check("R6 no early pulse", int'(out_valid), 0);
    @(posedge clk);
    #1 check("R6 pulse", int'(out_valid), 1);
    check("R4 detail", int'(detail_o), exp_d);
    check("R3 approx", int'(approx_o), exp_a);
    @(posedge clk);
    #1 check("R6 single pulse", int'(out_valid), 0);
    check("R7 approx hold", int'(approx_o), exp_a);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    m1 = 0; m2 = 0; m3 = 0; me = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset approx", int'(approx_o), 0);
    check("R1 reset detail", int'(detail_o), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk);
    #1 check("R1 after release", int'(out_valid), 0);

    // R2, R5: first pair after reset sees zero carries
    for (int i = 0; i < NVEC; i++) begin
      run_pair(VEC[i][0], VEC[i][1]);
    end

    // R2: even sample alone gives no output
    @(negedge clk); in_valid = 1; in_sample = 10'sd123;
    @(negedge clk); in_valid = 0;
    repeat (7) @(posedge clk);
    #1 check("R2 even only no pulse", int'(out_valid), 0);
    check("R7 detail hold", int'(detail_o), exp_d);

    // R9: reset drops the pending even and clears carries
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m1 = 0; m2 = 0; m3 = 0; me = 0;
    run_pair(-300, 200);
    run_pair(64, -64);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule